// File: doc/BRIEF.md
# Scanline Start Address Generator

This block produces the video memory start address of every displayed scanline in a character/graphics display controller. A frame-start pulse loads the address from the programmed start address. After that, a line-step pulse is given once per displayed line. On each step the block decides whether the next line repeats the current source row or moves to the next row. The number of repeats comes from the maximum-scanline register, with its scan-doubling bit folded in. In the two-colour shift mode a separate rule is used instead.

A row advance adds the line offset to the address. Two low bits of the mode-control register can suppress that addition on some rows. When the current displayed line equals the line-compare value, the address restarts at zero. This gives a split screen whose lower part shows memory from address 0. Steps past the last line of the frame are ignored.

The downstream pixel fetch reads `line_addr` as the byte address of the line being shown, and `line_num` as its displayed line index.

Top module: `scanline_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `line_addr` and `line_num` are 0.
- R2: A `frame_start` pulse sets `line_addr` to `start_addr` shifted left by two (start_addr × 4), sets `line_num` to 0, clears the row counter and reloads the repeat counter. It takes priority over a simultaneous `line_step`.
- R3: When `shift_ctrl` is not 1, the repeat value is (((max_scan[4:0] + 1) << max_scan[7]) − 1). Each source row is shown for repeat + 1 consecutive displayed lines.
- R4: When `shift_ctrl` equals 1, the repeat value is max_scan[7] alone, and max_scan[4:0] has no effect.
- R5: On a row advance, mask = mode_ctrl[1:0] XOR 2'b11. The byte offset `line_offset` × 8 is added to the address only when (row counter AND mask) == mask, with the row counter taken before it increments.
- R6: An accepted step taken while `line_num` equals `line_cmp` makes the next line's address 0. This overrides any offset addition on that step.
- R7: An accepted step increments `line_num` by one. A step with line_num + 1 >= `frame_height` is ignored, and both outputs hold.
- R8: All address additions wrap modulo 2^18.
- R9: With neither `frame_start` nor `line_step` asserted, both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Pulse at the top of the frame |
| line_step | input | 1 | Pulse once per displayed line |
| start_addr | input | 16 | Programmed display start address (units of 4 bytes) |
| line_offset | input | 8 | Row pitch in units of 8 bytes |
| max_scan | input | 8 | Maximum-scanline register: bit 7 scan doubling, bits 4:0 scan count |
| mode_ctrl | input | 8 | Mode-control register; bits 1:0 gate row advances |
| shift_ctrl | input | 2 | Graphics shift-control field |
| line_cmp | input | 10 | Split-screen line-compare value |
| frame_height | input | 10 | Number of displayed lines in the frame |
| line_addr | output | 18 | Start byte address of the current line |
| line_num | output | 10 | Index of the current displayed line |

## Verification
The address sequence is driven with plain doubling (repeat 1), deep multi-scan with doubling (repeat 7) and the two-colour shift mode with a large scan count. Together these separate the merged repeat formula from the shift-mode rule, and show that the scan field is ignored in that mode. All four mode-control bit pairs are stepped over many rows, so an inverted or misplaced mask, or a row counter sampled after its increment, gives wrong addresses. Further runs cover a line compare inside the frame, start and offset values that wrap the 18-bit address, steps past the frame height, idle cycles, and a frame start that coincides with a step.

// File: rtl/sla_pkg.sv
// Package: shared widths and the per-cycle action type of the scanline
// address generator. Assumes the repeat value never exceeds 63.
package sla_pkg;
    localparam int REP_W = 6;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_RELOAD = 2'd1,
        ACT_STEP   = 2'd2
    } sla_act_e;
endpackage

// File: rtl/sla_repeat_calc.sv
// Module: sla_repeat_calc
// Derives how many extra times each source row is repeated from the
// maximum-scanline register and the shift-control field. Purely combinational.
// Assumes shift value 1 selects the two-colour rule.
module sla_repeat_calc
    import sla_pkg::*;
(
    input  logic [7:0]       max_scan,
    input  logic [1:0]       shift_ctrl,
    output logic [REP_W-1:0] rep_val
);
    logic             dbl;
    logic [REP_W:0]   base;
    logic [REP_W:0]   scaled;

    // Merge scan count and doubling bit, or take the doubling bit alone.
    always_comb begin
        dbl    = max_scan[7];
        base   = {2'b00, max_scan[4:0]} + 7'd1;
        scaled = dbl ? (base << 1) : base;
        if (shift_ctrl == 2'd1) begin
            rep_val = {{(REP_W-1){1'b0}}, dbl};
        end else begin
            rep_val = REP_W'(scaled - 7'd1);
        end
    end
endmodule

// File: rtl/sla_row_stepper.sv
// Module: sla_row_stepper
// Holds the repeat down-counter and the source row counter. Flags when the
// current step is a row advance and whether the pre-increment row passes
// the mode-control mask. Assumes reload and step are mutually exclusive.
module sla_row_stepper
    import sla_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             step,
    input  logic [REP_W-1:0] rep_val,
    input  logic [1:0]       mode_bits,
    output logic             advance,
    output logic             row_hit
);
    logic [REP_W-1:0] rep_cnt;
    logic [ROW_W-1:0] row;
    logic [1:0]       mask;

    // Advance when the repeat counter is exhausted; test the row against the mask.
    always_comb begin
        mask    = mode_bits ^ 2'b11;
        advance = (rep_cnt == '0);
        row_hit = ((row[1:0] & mask) == mask);
    end

    // Count down repeats, bump the row and reload on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_cnt <= '0;
            row     <= '0;
        end else if (reload) begin
            rep_cnt <= rep_val;
            row     <= '0;
        end else if (step) begin
            if (advance) begin
                rep_cnt <= rep_val;
                row     <= row + 1'b1;
            end else begin
                rep_cnt <= rep_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sla_addr_accum.sv
// Module: sla_addr_accum
// Keeps the running line address: loads start*4, adds the row pitch on
// qualified advances, and clears on a split-screen hit. Wraps at ADDR_W bits.
// Assumes ADDR_W >= START_W + 2.
module sla_addr_accum #(
    parameter int ADDR_W  = 18,
    parameter int START_W = 16,
    parameter int OFFS_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reload,
    input  logic               step,
    input  logic               add_en,
    input  logic               cmp_hit,
    input  logic [START_W-1:0] start_addr,
    input  logic [OFFS_W-1:0]  line_offset,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] start_bytes;
    logic [ADDR_W-1:0] pitch_bytes;

    // Scale word units to byte addresses.
    always_comb begin
        start_bytes = ADDR_W'(start_addr) << 2;
        pitch_bytes = ADDR_W'(line_offset) << 3;
    end

    // Update the address; line compare overrides the pitch addition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (reload) begin
            addr <= start_bytes;
        end else if (step) begin
            if (cmp_hit) begin
                addr <= '0;
            end else if (add_en) begin
                addr <= addr + pitch_bytes;
            end
        end
    end
endmodule

// File: rtl/scanline_addr_gen.sv
// Module: scanline_addr_gen (top)
// Generates the start address and index of every displayed scanline.
// Decodes frame start and line steps into one action, gates steps past the
// frame height, and drives the row stepper and the address accumulator.
// Assumes frame_start and line_step are single-cycle pulses.
module scanline_addr_gen
    import sla_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int START_W = 16,
    parameter int OFFS_W  = 8,
    parameter int LINE_W  = 10,
    parameter int ROW_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_step,
    input  logic [START_W-1:0] start_addr,
    input  logic [OFFS_W-1:0]  line_offset,
    input  logic [7:0]         max_scan,
    input  logic [7:0]         mode_ctrl,
    input  logic [1:0]         shift_ctrl,
    input  logic [LINE_W-1:0]  line_cmp,
    input  logic [LINE_W-1:0]  frame_height,
    output logic [ADDR_W-1:0]  line_addr,
    output logic [LINE_W-1:0]  line_num
);
    sla_act_e         act;
    logic             in_frame;
    logic             reload;
    logic             step;
    logic             advance;
    logic             row_hit;
    logic             cmp_hit;
    logic [REP_W-1:0] rep_val;

    // Choose this cycle's action; frame start wins over a step.
    always_comb begin
        in_frame = (({1'b0, line_num} + 1'b1) < {1'b0, frame_height});
        if (frame_start)              act = ACT_RELOAD;
        else if (line_step && in_frame) act = ACT_STEP;
        else                          act = ACT_HOLD;
        reload  = (act == ACT_RELOAD);
        step    = (act == ACT_STEP);
        cmp_hit = (line_num == line_cmp);
    end

    sla_repeat_calc u_rep (
        .max_scan   (max_scan),
        .shift_ctrl (shift_ctrl),
        .rep_val    (rep_val)
    );

    sla_row_stepper #(.ROW_W(ROW_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .step      (step),
        .rep_val   (rep_val),
        .mode_bits (mode_ctrl[1:0]),
        .advance   (advance),
        .row_hit   (row_hit)
    );

    sla_addr_accum #(.ADDR_W(ADDR_W), .START_W(START_W), .OFFS_W(OFFS_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload      (reload),
        .step        (step),
        .add_en      (advance && row_hit),
        .cmp_hit     (cmp_hit),
        .start_addr  (start_addr),
        .line_offset (line_offset),
        .addr        (line_addr)
    );

    // Count displayed lines from the top of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_num <= '0;
        end else if (reload) begin
            line_num <= '0;
        end else if (step) begin
            line_num <= line_num + 1'b1;
        end
    end
endmodule

// File: rtl/sla_checker.sv
// Module: sla_checker
// Port-level properties of the scanline address generator, bound to the top.
module sla_checker #(
    parameter int ADDR_W  = 18,
    parameter int START_W = 16,
    parameter int LINE_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               line_step,
    input logic [START_W-1:0] start_addr,
    input logic [LINE_W-1:0]  line_cmp,
    input logic [LINE_W-1:0]  frame_height,
    input logic [ADDR_W-1:0]  line_addr,
    input logic [LINE_W-1:0]  line_num
);
    logic accepted;
    assign accepted = line_step && !frame_start &&
                      (({1'b0, line_num} + 1'b1) < {1'b0, frame_height});

    // R2: frame start loads start*4 and line 0
    assert_frame_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_num == '0) &&
                        (line_addr == (ADDR_W'($past(start_addr)) << 2)));

    // R6: a step on the compare line gives address 0
    assert_split_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && line_num == line_cmp) |=> (line_addr == '0));

    // R7: accepted step increments the line index
    assert_line_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> (line_num == $past(line_num) + 1'b1));

    // R7: steps past the frame height are ignored
    assert_past_height_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_step && !frame_start && !accepted) |=>
            ($stable(line_num) && $stable(line_addr)));

    // R9: idle cycles hold both outputs
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_step && !frame_start) |=> ($stable(line_num) && $stable(line_addr)));
endmodule

bind scanline_addr_gen sla_checker #(
    .ADDR_W(ADDR_W), .START_W(START_W), .LINE_W(LINE_W)
) u_sla_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .line_step    (line_step),
    .start_addr   (start_addr),
    .line_cmp     (line_cmp),
    .frame_height (frame_height),
    .line_addr    (line_addr),
    .line_num     (line_num)
);

// File: tb/tb_scanline_addr_gen.sv
module tb_scanline_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_step = 1'b0;
    logic [15:0] start_addr = '0;
    logic [7:0]  line_offset = '0;
    logic [7:0]  max_scan = '0;
    logic [7:0]  mode_ctrl = 8'h03;
    logic [1:0]  shift_ctrl = '0;
    logic [9:0]  line_cmp = 10'h3FF;
    logic [9:0]  frame_height = 10'd480;
    logic [17:0] line_addr;
    logic [9:0]  line_num;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [17:0] m_addr;
    int          m_row;
    int          m_rep;
    int          m_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanline_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_step(line_step),
        .start_addr(start_addr), .line_offset(line_offset), .max_scan(max_scan),
        .mode_ctrl(mode_ctrl), .shift_ctrl(shift_ctrl), .line_cmp(line_cmp),
        .frame_height(frame_height), .line_addr(line_addr), .line_num(line_num)
    );

    function automatic int rep_of();
        int d;
        d = int'(max_scan[7]);
        if (shift_ctrl == 2'd1) return d;
        return ((int'(max_scan[4:0]) + 1) << d) - 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req);
        chk(req, int'(line_addr), int'(m_addr));
        chk(req, int'(line_num), m_line);
    endtask

    task automatic model_reload();
        m_addr = 18'(start_addr) << 2;
        m_row  = 0;
        m_rep  = rep_of();
        m_line = 0;
    endtask

    task automatic model_step();
        int mask;
        if (m_line + 1 >= int'(frame_height)) return;
        if (m_rep == 0) begin
            mask = int'(mode_ctrl[1:0]) ^ 3;
            if ((m_row & mask) == mask) m_addr = m_addr + (18'(line_offset) << 3);
            m_row++;
            m_rep = rep_of();
        end else begin
            m_rep--;
        end
        if (m_line == int'(line_cmp)) m_addr = '0;
        m_line++;
    endtask

    task automatic do_frame(string req);
        @(negedge clk) frame_start = 1'b1;
        model_reload();
        @(negedge clk) frame_start = 1'b0;
        chk_out(req);
    endtask

    task automatic do_steps(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) line_step = 1'b1;
            model_step();
            @(negedge clk) line_step = 1'b0;
            chk_out(req);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset addr", int'(line_addr), 0);
        chk("R1 reset line", int'(line_num), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_double();
        start_addr = 16'h0100; line_offset = 8'd10; max_scan = 8'h80;
        shift_ctrl = 2'd0; mode_ctrl = 8'h03;
        do_frame("R2 frame load");
        chk("R2 start*4", int'(line_addr), 32'h400);
        do_steps(9, "R3 doubling");
        chk("R3 doubled rows", int'(line_addr), 32'h400 + 4 * 80);
    endtask

    task automatic t_multiscan();
        start_addr = 16'h0020; line_offset = 8'd5; max_scan = 8'h83;
        shift_ctrl = 2'd2; mode_ctrl = 8'h03;
        do_frame("R2 frame load multi");
        do_steps(8, "R3 multiscan");
        chk("R3 repeat 7 after 8 lines", int'(line_addr), 32'h80 + 40);
        do_steps(12, "R3 multiscan run");
    endtask

    task automatic t_cga();
        start_addr = 16'h0000; line_offset = 8'd4; max_scan = 8'h9F;
        shift_ctrl = 2'd1; mode_ctrl = 8'h03;
        do_frame("R2 frame load cga");
        do_steps(2, "R4 cga double");
        chk("R4 scan field ignored", int'(line_addr), 32);
        max_scan = 8'h1F;
        do_frame("R2 frame load cga single");
        do_steps(3, "R4 cga single");
        chk("R4 no doubling", int'(line_addr), 96);
    endtask

    task automatic t_rowskip();
        line_offset = 8'd2; max_scan = 8'h00; shift_ctrl = 2'd0; start_addr = 16'h0004;
        for (int m = 0; m < 4; m++) begin
            mode_ctrl = 8'(m) | 8'hF0;
            do_frame("R2 frame load mask");
            do_steps(10, "R5 row mask");
        end
        mode_ctrl = 8'h00;
        do_frame("R2 frame load mask0");
        do_steps(4, "R5 mask 3");
        chk("R5 one add in 4 rows", int'(line_addr), 16 + 16);
    endtask

    task automatic t_linecmp();
        start_addr = 16'h0200; line_offset = 8'd6; max_scan = 8'h01;
        shift_ctrl = 2'd0; mode_ctrl = 8'h03; line_cmp = 10'd5;
        do_frame("R2 frame load cmp");
        do_steps(6, "R6 line compare");
        chk("R6 zero after compare", int'(line_addr), 0);
        do_steps(6, "R6 after split");
        line_cmp = 10'h3FF;
    endtask

    task automatic t_wrap();
        start_addr = 16'hFFFF; line_offset = 8'd1; max_scan = 8'h00;
        shift_ctrl = 2'd0; mode_ctrl = 8'h03;
        do_frame("R2 frame load wrap");
        chk("R8 top start", int'(line_addr), 32'h3FFFC);
        do_steps(1, "R8 wrap");
        chk("R8 wrapped", int'(line_addr), 4);
    endtask

    task automatic t_height();
        frame_height = 10'd4; start_addr = 16'h0010; line_offset = 8'd1;
        max_scan = 8'h00; shift_ctrl = 2'd0; mode_ctrl = 8'h03;
        do_frame("R2 frame load height");
        do_steps(6, "R7 height limit");
        chk("R7 last line", int'(line_num), 3);
        chk("R7 addr held", int'(line_addr), 32'h40 + 24);
        frame_height = 10'd480;
    endtask

    task automatic t_idle_and_prio();
        start_addr = 16'h0030; line_offset = 8'd3; max_scan = 8'h00;
        do_frame("R2 frame load idle");
        do_steps(3, "R9 pre idle");
        repeat (5) @(negedge clk);
        chk_out("R9 idle hold");
        @(negedge clk) begin frame_start = 1'b1; line_step = 1'b1; end
        model_reload();
        @(negedge clk) begin frame_start = 1'b0; line_step = 1'b0; end
        chk_out("R2 priority over step");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_double();
                t_multiscan();
                t_cga();
                t_rowskip();
                t_linecmp();
                t_wrap();
                t_height();
                t_idle_and_prio();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule